// File: doc/BRIEF.md
# Virtual Address Region Decoder

This block takes a 32-bit virtual address together with the access kind (instruction fetch or data), the privilege level of the requester and the global translation-enable bit, and decides how the address is turned into a physical one. The address space is split into fixed windows. Two windows need page translation. When translation is on, an address in those windows is forwarded for a TLB lookup. When translation is off, the address is folded into the physical range. The direct-mapped window is folded into the physical range in every case. The store-queue and control-register windows pass through unchanged. Other accesses end in an address error.

The decoder sits in front of the TLB in a load/store or fetch pipeline. The classification itself is combinational. All results are captured in one register stage, so a request presented with `in_valid` in one cycle produces its result on the outputs in the next cycle.

Top module: `vaddr_region_dec`

## Requirements
- R1: With `xlate_en` = 1, an address with bit 31 clear, or in 0xC0000000..0xDFFFFFFF, yields `out_tlb_req` = 1, `out_paddr` equal to the virtual address, `out_grant` = 2'b00 (none) and `out_addr_err` = 0. This holds for any privilege level and access kind.
- R2: With `xlate_en` = 0, an address in those same windows yields `out_paddr` = address AND 0x1FFFFFFF and `out_grant` = 2'b10 (read/write), with no TLB request and no error.
- R3: An address in 0xE0000000..0xE3FFFFFF (store-queue window) yields `out_paddr` equal to the address and grant 2'b10. This holds in user mode and for fetches as well.
- R4: With `in_user` = 1, any address outside the R1 and R3 windows raises `out_addr_err`.
- R5: In privileged mode, an address in 0x80000000..0xBFFFFFFF yields `out_paddr` = address AND 0x1FFFFFFF and grant 2'b10, for both fetch and data accesses.
- R6: In privileged mode, an instruction fetch (`in_fetch` = 1) in 0xE4000000..0xFFFFFFFF raises `out_addr_err`.
- R7: A privileged data access whose top nibble is 0xF yields `out_paddr` equal to the address and grant 2'b10.
- R8: A privileged data access in 0xE4000000..0xEFFFFFFF raises `out_addr_err`.
- R9: Whenever `out_addr_err` = 1, `out_paddr` = 0, `out_grant` = 2'b00 and `out_tlb_req` = 0.
- R10: Results appear exactly one cycle after the request, with `out_valid` following `in_valid`. Without a request, and during reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_vaddr | input | 32 | Virtual address |
| in_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| in_user | input | 1 | 1 = user privilege, 0 = privileged |
| xlate_en | input | 1 | Page translation enabled |
| out_valid | output | 1 | Result valid |
| out_paddr | output | 32 | Physical address, or the virtual address when a TLB lookup is requested |
| out_grant | output | 2 | 2'b00 none, 2'b10 read/write |
| out_tlb_req | output | 1 | Address must be looked up in the TLB |
| out_addr_err | output | 1 | Access rejected |

## Verification
The assertions compare each registered result with the inputs one cycle earlier, using `$past`. They therefore assume that `in_valid` is low during reset, so that no request is lost at the first edge after reset. The stimulus keeps the request inputs idle throughout reset. After reset it changes them only on falling edges, one request per cycle or one idle cycle. The stimulus walks through every window boundary under all eight combinations of privilege, access kind and translation enable. A pseudo-random address sweep follows.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

    typedef enum logic [2:0] {
        RG_XLATE  = 3'd0,
        RG_STORE  = 3'd1,
        RG_DIRECT = 3'd2,
        RG_CTRL   = 3'd3,
        RG_RESV   = 3'd4
    } region_e;

    typedef enum logic [1:0] {
        GR_NONE = 2'b00,
        GR_RW   = 2'b10
    } grant_e;

    typedef struct packed {
        logic        valid;
        logic [31:0] paddr;
        grant_e      grant;
        logic        tlb_req;
        logic        addr_err;
    } result_t;

endpackage

// File: rtl/vrd_window.sv
module vrd_window #(
    parameter int          ADDR_W = 32,
    parameter logic [31:0] BASE   = 32'h0,
    parameter logic [31:0] LAST   = 32'hFFFF_FFFF
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] LO = BASE[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] HI = LAST[ADDR_W-1:0];
    localparam bit LO_OPEN = (LO == '0);
    localparam bit HI_OPEN = (HI == '1);

    generate
        if (LO_OPEN && HI_OPEN) begin : g_all
            assign hit = 1'b1;
        end else if (LO_OPEN) begin : g_upper
            assign hit = (addr <= HI);
        end else if (HI_OPEN) begin : g_lower
            assign hit = (addr >= LO);
        end else begin : g_both
            assign hit = (addr >= LO) && (addr <= HI);
        end
    endgenerate

endmodule

// File: rtl/vrd_classify.sv
module vrd_classify
    import vrd_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter logic [31:0] XL_LO_LAST = 32'h7FFF_FFFF,
    parameter logic [31:0] XL_HI_BASE = 32'hC000_0000,
    parameter logic [31:0] XL_HI_LAST = 32'hDFFF_FFFF,
    parameter logic [31:0] SQ_BASE    = 32'hE000_0000,
    parameter logic [31:0] SQ_LAST    = 32'hE3FF_FFFF,
    parameter logic [31:0] DM_BASE    = 32'h8000_0000,
    parameter logic [31:0] DM_LAST    = 32'hBFFF_FFFF,
    parameter logic [31:0] CR_BASE    = 32'hF000_0000
) (
    input  logic [ADDR_W-1:0] vaddr,
    output region_e           region
);
    logic hit_xl_lo, hit_xl_hi, hit_sq, hit_dm, hit_cr;

    vrd_window #(.ADDR_W(ADDR_W), .BASE(32'h0),      .LAST(XL_LO_LAST))
        u_xl_lo (.addr(vaddr), .hit(hit_xl_lo));
    vrd_window #(.ADDR_W(ADDR_W), .BASE(XL_HI_BASE), .LAST(XL_HI_LAST))
        u_xl_hi (.addr(vaddr), .hit(hit_xl_hi));
    vrd_window #(.ADDR_W(ADDR_W), .BASE(SQ_BASE),    .LAST(SQ_LAST))
        u_sq    (.addr(vaddr), .hit(hit_sq));
    vrd_window #(.ADDR_W(ADDR_W), .BASE(DM_BASE),    .LAST(DM_LAST))
        u_dm    (.addr(vaddr), .hit(hit_dm));
    vrd_window #(.ADDR_W(ADDR_W), .BASE(CR_BASE),    .LAST(32'hFFFF_FFFF))
        u_cr    (.addr(vaddr), .hit(hit_cr));

    // Priority follows the decode order: translated, store queue, direct, control.
    always_comb begin
        if (hit_xl_lo || hit_xl_hi) begin
            region = RG_XLATE;
        end else if (hit_sq) begin
            region = RG_STORE;
        end else if (hit_dm) begin
            region = RG_DIRECT;
        end else if (hit_cr) begin
            region = RG_CTRL;
        end else begin
            region = RG_RESV;
        end
    end

endmodule

// File: rtl/vrd_map.sv
module vrd_map
    import vrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PHYS_W = 29
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] vaddr,
    input  region_e           region,
    input  logic              fetch,
    input  logic              user,
    input  logic              xlate_en,
    output result_t           res
);
    localparam logic [ADDR_W-1:0] PHYS_MASK = ADDR_W'((64'd1 << PHYS_W) - 64'd1);

    logic [ADDR_W-1:0] folded;
    logic [31:0]       folded_w;
    logic [31:0]       raw_w;

    assign folded   = vaddr & PHYS_MASK;
    assign folded_w = 32'(folded);
    assign raw_w    = 32'(vaddr);

    always_comb begin
        res          = '0;
        res.valid    = req;
        res.grant    = GR_NONE;
        if (req) begin
            unique case (region)
                RG_XLATE: begin
                    if (xlate_en) begin
                        res.tlb_req = 1'b1;
                        res.paddr   = raw_w;
                    end else begin
                        res.paddr   = folded_w;
                        res.grant   = GR_RW;
                    end
                end
                RG_STORE: begin
                    res.paddr = raw_w;
                    res.grant = GR_RW;
                end
                RG_DIRECT: begin
                    if (user) begin
                        res.addr_err = 1'b1;
                    end else begin
                        res.paddr = folded_w;
                        res.grant = GR_RW;
                    end
                end
                RG_CTRL: begin
                    if (user || fetch) begin
                        res.addr_err = 1'b1;
                    end else begin
                        res.paddr = raw_w;
                        res.grant = GR_RW;
                    end
                end
                default: begin
                    res.addr_err = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/vaddr_region_dec.sv
module vaddr_region_dec
    import vrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int PHYS_W = 29
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_vaddr,
    input  logic        in_fetch,
    input  logic        in_user,
    input  logic        xlate_en,
    output logic        out_valid,
    output logic [31:0] out_paddr,
    output logic [1:0]  out_grant,
    output logic        out_tlb_req,
    output logic        out_addr_err
);
    region_e region;
    result_t map_res;
    result_t res_d, res_q;
    logic [ADDR_W-1:0] va;

    assign va = in_vaddr[ADDR_W-1:0];

    vrd_classify #(.ADDR_W(ADDR_W)) u_classify (
        .vaddr  (va),
        .region (region)
    );

    vrd_map #(.ADDR_W(ADDR_W), .PHYS_W(PHYS_W)) u_map (
        .req      (in_valid),
        .vaddr    (va),
        .region   (region),
        .fetch    (in_fetch),
        .user     (in_user),
        .xlate_en (xlate_en),
        .res      (map_res)
    );

    always_comb begin
        res_d = map_res;
        if (!map_res.valid) begin
            res_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid    = res_q.valid;
    assign out_paddr    = res_q.paddr;
    assign out_grant    = res_q.grant;
    assign out_tlb_req  = res_q.tlb_req;
    assign out_addr_err = res_q.addr_err;

endmodule

// File: rtl/vaddr_region_dec_chk.sv
module vaddr_region_dec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] in_vaddr,
    input logic        in_fetch,
    input logic        in_user,
    input logic        xlate_en,
    input logic        out_valid,
    input logic [31:0] out_paddr,
    input logic [1:0]  out_grant,
    input logic        out_tlb_req,
    input logic        out_addr_err
);
    logic in_xl, in_sq, in_dm;
    assign in_xl = !in_vaddr[31] || (in_vaddr[31:29] == 3'b110);
    assign in_sq = (in_vaddr[31:26] == 6'b111000);
    assign in_dm = (in_vaddr[31:30] == 2'b10);

    a_r1_tlb_forward: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_xl && xlate_en) |-> out_tlb_req && out_paddr == $past(in_vaddr));

    a_r2_bypass_fold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_xl && !xlate_en) |-> !out_tlb_req && out_paddr == ($past(in_vaddr) & 32'h1FFF_FFFF));

    a_r3_store_pass: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_sq) |-> out_paddr == $past(in_vaddr) && out_grant == 2'b10);

    a_r4_user_reject: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_user && !in_xl && !in_sq) |-> out_addr_err);

    a_r5_direct_fold: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(!in_user && in_dm) |-> out_paddr == ($past(in_vaddr) & 32'h1FFF_FFFF) && !out_addr_err);

    a_r6_fetch_reject: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(in_fetch && !in_xl && !in_sq && !in_dm) |-> out_addr_err);

    a_r9_error_clean: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr_err |-> out_paddr == 32'h0 && out_grant == 2'b00 && !out_tlb_req);

    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_tlb_req, out_addr_err}));

    a_r10_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_tlb_req && !out_addr_err && out_grant == 2'b00);

endmodule

bind vaddr_region_dec vaddr_region_dec_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_vaddr     (in_vaddr),
    .in_fetch     (in_fetch),
    .in_user      (in_user),
    .xlate_en     (xlate_en),
    .out_valid    (out_valid),
    .out_paddr    (out_paddr),
    .out_grant    (out_grant),
    .out_tlb_req  (out_tlb_req),
    .out_addr_err (out_addr_err)
);

// File: tb/vaddr_region_dec_tb_top.sv
module vaddr_region_dec_tb_top;

    typedef struct packed {
        logic [31:0] paddr;
        logic [1:0]  grant;
        logic        tlb_req;
        logic        err;
        logic [3:0]  rid;
        logic [31:0] va;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_vaddr = '0;
    logic        in_fetch = 1'b0;
    logic        in_user = 1'b0;
    logic        xlate_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_paddr;
    logic [1:0]  out_grant;
    logic        out_tlb_req;
    logic        out_addr_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    vaddr_region_dec dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vaddr(in_vaddr),
        .in_fetch(in_fetch), .in_user(in_user), .xlate_en(xlate_en),
        .out_valid(out_valid), .out_paddr(out_paddr), .out_grant(out_grant),
        .out_tlb_req(out_tlb_req), .out_addr_err(out_addr_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] va, input bit f, input bit u, input bit x);
        exp_t e;
        bit xl, sq, dm, cr;
        e = '0;
        e.va = va;
        xl = (va < 32'h8000_0000) || (va >= 32'hC000_0000 && va < 32'hE000_0000);
        sq = (va >= 32'hE000_0000 && va < 32'hE400_0000);
        dm = (va >= 32'h8000_0000 && va < 32'hC000_0000);
        cr = (va[31:28] == 4'hF);
        if (xl && x) begin            // R1
            e.tlb_req = 1'b1; e.paddr = va; e.rid = 4'd1;
        end else if (xl) begin        // R2
            e.paddr = va & 32'h1FFF_FFFF; e.grant = 2'b10; e.rid = 4'd2;
        end else if (sq) begin        // R3
            e.paddr = va; e.grant = 2'b10; e.rid = 4'd3;
        end else if (u) begin         // R4
            e.err = 1'b1; e.rid = 4'd4;
        end else if (dm) begin        // R5
            e.paddr = va & 32'h1FFF_FFFF; e.grant = 2'b10; e.rid = 4'd5;
        end else if (f) begin         // R6
            e.err = 1'b1; e.rid = 4'd6;
        end else if (cr) begin        // R7
            e.paddr = va; e.grant = 2'b10; e.rid = 4'd7;
        end else begin                // R8
            e.err = 1'b1; e.rid = 4'd8;
        end
        return e;
    endfunction

    task automatic send(input logic [31:0] va, input bit f, input bit u, input bit x);
        @(negedge clk);
        in_valid = 1'b1; in_vaddr = va; in_fetch = f; in_user = u; xlate_en = x;
        sb.push_back(model(va, f, u, x));
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_vaddr = 32'hDEAD_BEEF;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Monitor: one register stage, so results are sampled just after the capturing edge.
    initial begin
        exp_t e;
        string tag;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10 unexpected result", 64'(out_paddr), 64'h0);
                end else begin
                    e = sb.pop_front();
                    tag = $sformatf("R%0d va=%h", e.rid, e.va);
                    check(out_paddr == e.paddr, {tag, " paddr"}, 64'(out_paddr), 64'(e.paddr));
                    check(out_grant == e.grant, {tag, " grant"}, 64'(out_grant), 64'(e.grant));
                    check(out_tlb_req == e.tlb_req, {tag, " tlb_req"}, 64'(out_tlb_req), 64'(e.tlb_req));
                    // R9: error results carry no address, grant or lookup
                    check(out_addr_err == e.err, {tag, " R9 err"}, 64'(out_addr_err), 64'(e.err));
                end
            end else begin
                check(!out_tlb_req && !out_addr_err && out_grant == 2'b00,
                      "R10 idle outputs", 64'({out_tlb_req, out_addr_err, out_grant}), 64'h0);
                check(sb.size() == 0, "R10 missing result", 64'(sb.size()), 64'h0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 64'h0, 64'h1);
            finish_run();
        end
    end

    initial begin
        logic [31:0] lfsr;
        logic [31:0] corners [13];
        corners = '{32'h0000_1234, 32'h7FFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
                    32'hE000_0000, 32'hE3FF_FFFF, 32'hE400_0000, 32'hEFFF_FFFF,
                    32'h8000_0000, 32'hBFFF_FFFF, 32'hF000_0000, 32'hFFFF_FFFF,
                    32'hA123_4567};
        repeat (4) @(negedge clk);
        // R10: reset state
        check(out_valid == 1'b0 && out_paddr == 32'h0, "R10 reset state",
              64'({out_valid, out_paddr}), 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        idle();
        // Corner sweep: all privilege/kind/translation combinations (R1..R8)
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 13; i++) begin
                send(corners[i], m[0], m[1], m[2]);
            end
            idle();
        end
        // Pseudo-random sweep with occasional gaps
        lfsr = 32'h1357_9BDF;
        for (int k = 0; k < 300; k++) begin
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            send(lfsr, lfsr[3], lfsr[7], lfsr[11]);
            if (lfsr[5:4] == 2'b00) idle();
        end
        repeat (3) idle();
        done = 1'b1;
        finish_run();
    end

endmodule